// File: doc/BRIEF.md
# Mixed-Trigger Interrupt Aggregator

This block merges thirty-two interrupt sources into one request line for the processor. Every bit position has a fixed trigger type. Most positions are live levels. A chosen set of positions is edge-sensitive: a rising edge on one of these inputs is captured in a sticky latch. That latch holds the bit until software writes the bit back as zero. Three of the level positions carry summary lines from a secondary controller. Three of the edge positions can also be raised from software.

Software uses a small register port to read the status, to program the enable mask, to clear latched edges and to raise software interrupts. A scratch control register returns the last value written to it. Its only use is as a harmless read target that forces earlier posted writes to complete. The block qualifies status with the mask to form the pending set. It drives a registered request line and gives the index of the lowest-numbered pending source, so a handler can dispatch without scanning.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the mask (addr 1), latch (addr 2), software (addr 3) and control (addr 4) registers read zero. The request output is low and the index valid flag is low.
- R2: The level positions are every bit except 16–19, 22–24 and 28–30. Their status bits (addr 0) equal the live input, including the summary lines on bits 4 (super-I/O group), 5 (miscellaneous group) and 6 (audio group).
- R3: A rising edge on an edge position (bits 16–19, 22–24, 28–30) sets that bit in the latch register one clock later. The bit stays set after the input falls.
- R4: Writing the latch register (addr 2) clears each edge bit written as 0 and leaves each bit written as 1 unchanged.
- R5: When a rising edge and a clearing write hit the same latch bit in the same cycle, the bit ends set.
- R6: Writes to the latch register do not change level positions. The latch register always reads zero there, and level status keeps following the input.
- R7: Writing the software register (addr 3) stores only bits 28–30. Those stored bits appear in status and stay until they are rewritten as zero.
- R8: Pending is status AND mask. The request output equals the OR of pending, delayed by exactly one clock.
- R9: The index output gives the lowest set pending bit, and the valid flag is high. When nothing is pending the valid flag is low and the index is 0.
- R10: A read of the control register (addr 4) returns the last data written there. Writing or reading it changes no other register or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Interrupt source inputs |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational from addr_i) |
| irq_o | output | 1 | Registered interrupt request to the processor |
| idx_o | output | 5 | Lowest pending source index |
| idx_valid_o | output | 1 | Index is meaningful |

## Verification
The capture of a new rising edge and a software clear of the same latch bit can fall in the same clock. The bench provokes this by raising bit 23 at the same falling edge where it issues a write of all zeros to the latch register. Earlier in that test, bit 22 was latched by its own edge. On readback, bit 23 must be set because capture wins. Bit 22 must be clear because the same write cleared it.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int          NSRC      = 32,
  parameter int          AW        = 3,
  parameter logic [31:0] EDGE_BITS = 32'h71CF_0000,
  parameter logic [31:0] SOFT_BITS = 32'h7000_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         src_i,
  input  logic                    wr_en_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [NSRC-1:0]         wdata_i,
  output logic [NSRC-1:0]         rdata_o,
  output logic                    irq_o,
  output logic [$clog2(NSRC)-1:0] idx_o,
  output logic                    idx_valid_o
);
  localparam int IW = $clog2(NSRC);
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_MASK = AW'(1);
  localparam logic [AW-1:0] A_HARD = AW'(2);
  localparam logic [AW-1:0] A_SOFT = AW'(3);
  localparam logic [AW-1:0] A_CTRL = AW'(4);
  localparam logic [NSRC-1:0] EDGE = EDGE_BITS[NSRC-1:0];
  localparam logic [NSRC-1:0] SOFT = SOFT_BITS[NSRC-1:0];

  logic [NSRC-1:0] src_q, hard_q, soft_q, mask_q, ctrl_q;
  logic [NSRC-1:0] rise, status, pending, hard_clr;

  assign rise     = src_i & ~src_q & EDGE;
  assign hard_clr = (wr_en_i && addr_i == A_HARD) ? (~wdata_i & EDGE) : '0;
  assign status   = (src_i & ~EDGE) | hard_q | soft_q;
  assign pending  = status & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      hard_q <= '0;
      soft_q <= '0;
      mask_q <= '0;
      ctrl_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      src_q  <= src_i;
      hard_q <= (hard_q & ~hard_clr) | rise;
      irq_o  <= |pending;
      if (wr_en_i) begin
        case (addr_i)
          A_MASK:  mask_q <= wdata_i;
          A_SOFT:  soft_q <= wdata_i & SOFT;
          A_CTRL:  ctrl_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_STAT:  rdata_o = status;
      A_MASK:  rdata_o = mask_q;
      A_HARD:  rdata_o = hard_q;
      A_SOFT:  rdata_o = soft_q;
      A_CTRL:  rdata_o = ctrl_q;
      default: rdata_o = '0;
    endcase
  end

  always_comb begin
    idx_o       = '0;
    idx_valid_o = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pending[i]) begin
        idx_o       = IW'(i);
        idx_valid_o = 1'b1;
      end
    end
  end

  assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == A_HARD) |=> (($past(hard_q) & ~hard_q) == '0));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((hard_q & $past(rise)) == $past(rise)));

  assert_no_level_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hard_q & ~EDGE) == '0);

  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid_o |=> irq_o);

  assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_valid_o |=> !irq_o);

  always_comb begin
    if (rst_n && idx_valid_o) begin
      assert_idx_lowest_R9: assert (pending[idx_o] &&
        ((pending & ((NSRC'(1) << idx_o) - NSRC'(1))) == '0));
    end
  end
endmodule

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [4:0]  idx;
  logic        idx_valid;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  irq_aggregator dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .idx_o(idx),
    .idx_valid_o(idx_valid)
  );

  // src, mask, expected status, expected index, expected valid
  localparam int NV = 7;
  localparam logic [101:0] VEC [NV] = '{
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 5'd0,  1'b0},
    {32'h0000_0070, 32'hFFFF_FFFF, 32'h0000_0070, 5'd4,  1'b1},
    {32'h0000_0070, 32'h0000_0040, 32'h0000_0070, 5'd6,  1'b1},
    {32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 5'd31, 1'b1},
    {32'h0E20_0000, 32'h0C00_0000, 32'h0E20_0000, 5'd26, 1'b1},
    {32'h0000_FFFF, 32'h0000_0000, 32'h0000_FFFF, 5'd0,  1'b0},
    {32'h0030_0001, 32'h0030_0000, 32'h0030_0001, 5'd20, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd1, v); chk("R1 mask", v, 0);
    rd(3'd2, v); chk("R1 latch", v, 0);
    rd(3'd3, v); chk("R1 soft", v, 0);
    rd(3'd4, v); chk("R1 ctrl", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 valid", {31'b0, idx_valid}, 0);

    // R2 / R8 / R9 vector table on level positions
    for (int i = 0; i < NV; i++) begin
      wr(3'd1, VEC[i][69:38]);
      src = VEC[i][101:70];
      rd(3'd0, v);
      chk("R2 status", v, VEC[i][37:6]);
      chk("R9 index", {27'b0, idx}, {27'b0, VEC[i][5:1]});
      chk("R9 valid", {31'b0, idx_valid}, {31'b0, VEC[i][0]});
      @(negedge clk);
      chk("R8 irq", {31'b0, irq}, {31'b0, VEC[i][0]});
    end

    // R8 one-clock delay
    src = 32'h0; wr(3'd1, 32'hFFFF_FFFF);
    @(negedge clk);
    src = 32'h8000_0000;
    #1 chk("R8 irq before edge", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R8 irq after edge", {31'b0, irq}, 1);
    src = 32'h0;
    @(negedge clk);

    // R3 edge capture and hold
    src = 32'h0001_0000;
    @(negedge clk);
    rd(3'd2, v); chk("R3 latch set", v, 32'h0001_0000);
    src = 32'h0;
    repeat (2) @(negedge clk);
    rd(3'd2, v); chk("R3 latch held", v, 32'h0001_0000);
    rd(3'd0, v); chk("R3 status", v, 32'h0001_0000);
    chk("R8 irq edge", {31'b0, irq}, 1);

    // R4 ones keep, zero clears
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R4 ones keep", v, 32'h0001_0000);
    wr(3'd2, 32'hFFFE_FFFF);
    rd(3'd2, v); chk("R4 zero clears", v, 0);

    // R6 level positions unaffected by latch writes
    src = 32'h0000_0001;
    wr(3'd2, 32'h0000_0000);
    rd(3'd0, v); chk("R6 level status", v, 32'h0000_0001);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R6 latch level bits", v, 0);
    src = 32'h0;

    // R5 capture beats same-cycle clear
    @(negedge clk);
    src = 32'h0040_0000;
    @(negedge clk);
    src = 32'h0;
    @(negedge clk);
    src = 32'h0080_0000;
    wr_en = 1'b1; addr = 3'd2; wdata = 32'h0;
    @(negedge clk);
    wr_en = 1'b0;
    rd(3'd2, v); chk("R5 set wins", v, 32'h0080_0000);

    // R9 lowest across level and latched
    src = 32'h0000_0020;
    #1 chk("R9 mixed low", {27'b0, idx}, 32'd5);
    wr(3'd1, 32'hFFFF_FFDF);
    chk("R9 mixed masked", {27'b0, idx}, 32'd23);
    src = 32'h0;
    wr(3'd2, 32'h0);

    // R7 software raise
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, v); chk("R7 soft stored", v, 32'h7000_0000);
    rd(3'd0, v); chk("R7 soft status", v, 32'h7000_0000);
    wr(3'd1, 32'h4000_0000);
    chk("R7 soft index", {27'b0, idx}, 32'd30);
    repeat (2) @(negedge clk);
    rd(3'd3, v); chk("R7 soft held", v, 32'h7000_0000);
    wr(3'd3, 32'h0);
    rd(3'd0, v); chk("R7 soft cleared", v, 0);
    chk("R9 none valid", {31'b0, idx_valid}, 0);
    chk("R9 none index", {27'b0, idx}, 0);

    // R10 control scratch
    wr(3'd4, 32'hA5A5_1234);
    rd(3'd4, v); chk("R10 ctrl read", v, 32'hA5A5_1234);
    rd(3'd4, v); chk("R10 ctrl reread", v, 32'hA5A5_1234);
    rd(3'd1, v); chk("R10 mask kept", v, 32'h4000_0000);
    rd(3'd2, v); chk("R10 latch kept", v, 0);
    chk("R10 irq kept", {31'b0, irq}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule